// File: doc/BRIEF.md
# Atomic Read-Modify-Write Unit

This block performs one indivisible read-modify-write on a single 64-bit memory word for a single requester. A request carries an opcode, a byte address, an operand size and up to two operand values. The unit reads the addressed word over a ready/valid memory port, takes the selected lane and computes the new lane value. It writes that lane back under byte enables and then returns the lane's previous contents.

The opcodes are arithmetic add, bitwise xor, or and and, signed and unsigned maximum and minimum, swap, and compare-exchange. Compare-exchange also returns a flag that tells whether the store happened. Operands may be 8, 16, 32 or 64 bits wide. The unit holds off new requests until the current one has produced its response, so no other access can reach the port between the read and the write.

Top module: `amo_unit`

## Requirements
- R1: Opcodes 0 (add), 1 (xor), 2 (or) and 3 (and) write lane OP operand into the lane and respond with the lane's prior value (zero-extended), `rsp_stored`=1 and `rsp_err`=0.
- R2: Addition wraps modulo the operand width; bytes outside the lane keep their value.
- R3: Opcodes 4 (unsigned max), 5 (signed max), 6 (unsigned min) and 7 (signed min) store the larger or smaller of lane and operand. Signed variants sign-extend both at the operand width; unsigned variants zero-extend.
- R4: Opcode 8 (swap) stores `req_opa`'s lane bits and returns the prior lane value.
- R5: Opcode 9 (compare-exchange) compares the lane with the low bits of `req_opb`. If they are equal, it stores `req_opa`'s lane bits with `rsp_stored`=1. If not, it issues no write and sets `rsp_stored`=0. Either way it returns the prior lane value.
- R6: `req_size` 0/1/2/3 selects 8/16/32/64 bits. `req_addr[2:0]` is the byte offset of the lane in the little-endian word. On write-back only that lane's `mem_req_be` bits are set, and `mem_req_addr` is `req_addr[ADDR_W-1:3]`.
- R7: An address whose low bits are not a multiple of the operand size in bytes gets `rsp_err`=1, `rsp_stored`=0, `rsp_old`=0 and no memory access.
- R8: An opcode above 9 is rejected the same way as R7.
- R9: A request performs exactly one read followed by at most one write to the same word. `req_ready` stays low from acceptance until the cycle after the response.
- R10: A memory request holds valid, address, write flag and data stable until `mem_req_ready` is seen.
- R11: `rsp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle and able to take a request |
| req_op | input | 4 | Opcode |
| req_addr | input | ADDR_W | Byte address |
| req_size | input | 2 | Operand size code |
| req_opa | input | 64 | Operand, swap value or replacement value |
| req_opb | input | 64 | Comparand for compare-exchange |
| rsp_valid | output | 1 | Response pulse |
| rsp_old | output | 64 | Prior lane value, zero-extended |
| rsp_stored | output | 1 | Write-back took place |
| rsp_err | output | 1 | Request rejected |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_we | output | 1 | 1 = write, 0 = read |
| mem_req_addr | output | ADDR_W-3 | Word address |
| mem_req_wdata | output | 64 | Write data, lane in place |
| mem_req_be | output | 8 | Byte enables for write |
| mem_rsp_valid | input | 1 | Read data or write acknowledge |
| mem_rsp_rdata | input | 64 | Read data |

## Verification
The assertions watch the port protocol on every cycle: a stalled memory request stays stable, no memory request appears while the unit is idle, and responses last one cycle. They also check that rejected requests answer in the next cycle without a port access and never report a store, and that write enables cover a legal lane width. Only the scoreboard scenarios can show the data results. These include lane wrap on addition, the signed versus unsigned ordering at the sign boundary, the compare-exchange hit and miss, the untouched neighbouring bytes, and the per-request access count against a memory model with stalls.

// File: rtl/amo_pkg.sv
package amo_pkg;
  localparam int SZ_W = 2;
  localparam int OP_W = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_XOR  = 4'd1,
    OP_OR   = 4'd2,
    OP_AND  = 4'd3,
    OP_UMAX = 4'd4,
    OP_SMAX = 4'd5,
    OP_UMIN = 4'd6,
    OP_SMIN = 4'd7,
    OP_SWAP = 4'd8,
    OP_CAS  = 4'd9
  } amo_op_e;

  localparam logic [OP_W-1:0] OP_LAST = 4'd9;
endpackage

// File: rtl/amo_lane.sv
module amo_lane import amo_pkg::*; #(
  parameter int DATA_W = 64,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB)
) (
  input  logic [DATA_W-1:0] word,
  input  logic [OFF_W-1:0]  off,
  input  logic [SZ_W-1:0]   size,
  input  logic [DATA_W-1:0] ins_val,
  output logic [DATA_W-1:0] lane_out,
  output logic [DATA_W-1:0] ins_word,
  output logic [NB-1:0]     ins_be
);
  logic [DATA_W-1:0] mask;
  logic [NB-1:0]     be_base;

  always_comb begin
    case (size)
      2'd0:    begin mask = DATA_W'(8'hFF);        be_base = NB'(4'h1); end
      2'd1:    begin mask = DATA_W'(16'hFFFF);     be_base = NB'(4'h3); end
      2'd2:    begin mask = DATA_W'(32'hFFFFFFFF); be_base = NB'(4'hF); end
      default: begin mask = '1;                    be_base = '1;        end
    endcase
  end

  assign lane_out = (word >> {off, 3'b000}) & mask;
  assign ins_word = (ins_val & mask) << {off, 3'b000};
  assign ins_be   = be_base << off;
endmodule

// File: rtl/amo_alu.sv
module amo_alu import amo_pkg::*; #(
  parameter int DATA_W = 64
) (
  input  logic [OP_W-1:0]   op,
  input  logic [SZ_W-1:0]   size,
  input  logic [DATA_W-1:0] cur,
  input  logic [DATA_W-1:0] opa,
  input  logic [DATA_W-1:0] opb,
  output logic [DATA_W-1:0] result,
  output logic              do_write
);
  localparam int NSZ = 1 << SZ_W;

  logic [DATA_W-1:0] cur_sx [NSZ];
  logic [DATA_W-1:0] opa_sx [NSZ];
  logic [DATA_W-1:0] mask, am, bm, sc, sa;

  for (genvar gi = 0; gi < NSZ; gi++) begin : g_ext
    localparam int W = 8 << gi;
    if (W < DATA_W) begin : g_narrow
      assign cur_sx[gi] = {{(DATA_W-W){cur[W-1]}}, cur[W-1:0]};
      assign opa_sx[gi] = {{(DATA_W-W){opa[W-1]}}, opa[W-1:0]};
    end else begin : g_full
      assign cur_sx[gi] = cur;
      assign opa_sx[gi] = opa;
    end
  end

  always_comb begin
    case (size)
      2'd0:    mask = DATA_W'(8'hFF);
      2'd1:    mask = DATA_W'(16'hFFFF);
      2'd2:    mask = DATA_W'(32'hFFFFFFFF);
      default: mask = '1;
    endcase
    am = opa & mask;
    bm = opb & mask;
    sc = cur_sx[size];
    sa = opa_sx[size];
    do_write = 1'b1;
    case (op)
      OP_ADD:  result = (cur + am) & mask;
      OP_XOR:  result = cur ^ am;
      OP_OR:   result = cur | am;
      OP_AND:  result = cur & am;
      OP_UMAX: result = (am > cur) ? am : cur;
      OP_SMAX: result = ($signed(sa) > $signed(sc)) ? am : cur;
      OP_UMIN: result = (am < cur) ? am : cur;
      OP_SMIN: result = ($signed(sa) < $signed(sc)) ? am : cur;
      OP_SWAP: result = am;
      default: begin
        result   = am;
        do_write = (cur == bm);
      end
    endcase
  end
endmodule

// File: rtl/amo_unit.sv
module amo_unit import amo_pkg::*; #(
  parameter int DATA_W = 64,
  parameter int ADDR_W = 16,
  localparam int NB    = DATA_W / 8,
  localparam int OFF_W = $clog2(NB),
  localparam int WA_W  = ADDR_W - OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [OP_W-1:0]   req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SZ_W-1:0]   req_size,
  input  logic [DATA_W-1:0] req_opa,
  input  logic [DATA_W-1:0] req_opb,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_old,
  output logic              rsp_stored,
  output logic              rsp_err,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_we,
  output logic [WA_W-1:0]   mem_req_addr,
  output logic [DATA_W-1:0] mem_req_wdata,
  output logic [NB-1:0]     mem_req_be,
  input  logic              mem_rsp_valid,
  input  logic [DATA_W-1:0] mem_rsp_rdata
);
  typedef enum logic [2:0] {S_IDLE, S_RD, S_RDW, S_WR, S_WRW, S_RESP} state_e;

  state_e            state;
  logic [OP_W-1:0]   op_q;
  logic [SZ_W-1:0]   size_q;
  logic [OFF_W-1:0]  off_q;
  logic [DATA_W-1:0] opa_q, opb_q, old_q;

  logic [DATA_W-1:0] cur_lane, alu_res, wr_word;
  logic [NB-1:0]     wr_be;
  logic              alu_wr;
  logic [OFF_W-1:0]  align_mask;
  logic              misaligned, bad_op;

  assign align_mask = OFF_W'((1 << req_size) - 1);
  assign misaligned = |(req_addr[OFF_W-1:0] & align_mask);
  assign bad_op     = (req_op > OP_LAST);

  amo_lane #(.DATA_W(DATA_W)) u_lane (
    .word(mem_rsp_rdata), .off(off_q), .size(size_q), .ins_val(alu_res),
    .lane_out(cur_lane), .ins_word(wr_word), .ins_be(wr_be)
  );

  amo_alu #(.DATA_W(DATA_W)) u_alu (
    .op(op_q), .size(size_q), .cur(cur_lane), .opa(opa_q), .opb(opb_q),
    .result(alu_res), .do_write(alu_wr)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      req_ready     <= 1'b1;
      rsp_valid     <= 1'b0;
      rsp_old       <= '0;
      rsp_stored    <= 1'b0;
      rsp_err       <= 1'b0;
      mem_req_valid <= 1'b0;
      mem_req_we    <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
      mem_req_be    <= '0;
      op_q          <= '0;
      size_q        <= '0;
      off_q         <= '0;
      opa_q         <= '0;
      opb_q         <= '0;
      old_q         <= '0;
    end else begin
      case (state)
        S_IDLE: if (req_valid) begin
          req_ready <= 1'b0;
          op_q      <= req_op;
          size_q    <= req_size;
          off_q     <= req_addr[OFF_W-1:0];
          opa_q     <= req_opa;
          opb_q     <= req_opb;
          if (misaligned || bad_op) begin
            rsp_valid  <= 1'b1;
            rsp_err    <= 1'b1;
            rsp_stored <= 1'b0;
            rsp_old    <= '0;
            state      <= S_RESP;
          end else begin
            mem_req_valid <= 1'b1;
            mem_req_we    <= 1'b0;
            mem_req_addr  <= req_addr[ADDR_W-1:OFF_W];
            state         <= S_RD;
          end
        end
        S_RD: if (mem_req_ready) begin
          mem_req_valid <= 1'b0;
          state         <= S_RDW;
        end
        S_RDW: if (mem_rsp_valid) begin
          old_q <= cur_lane;
          if (alu_wr) begin
            mem_req_valid <= 1'b1;
            mem_req_we    <= 1'b1;
            mem_req_wdata <= wr_word;
            mem_req_be    <= wr_be;
            state         <= S_WR;
          end else begin
            rsp_valid  <= 1'b1;
            rsp_err    <= 1'b0;
            rsp_stored <= 1'b0;
            rsp_old    <= cur_lane;
            state      <= S_RESP;
          end
        end
        S_WR: if (mem_req_ready) begin
          mem_req_valid <= 1'b0;
          mem_req_we    <= 1'b0;
          state         <= S_WRW;
        end
        S_WRW: if (mem_rsp_valid) begin
          rsp_valid  <= 1'b1;
          rsp_err    <= 1'b0;
          rsp_stored <= 1'b1;
          rsp_old    <= old_q;
          state      <= S_RESP;
        end
        default: begin
          rsp_valid <= 1'b0;
          req_ready <= 1'b1;
          state     <= S_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/amo_unit_chk.sv
module amo_unit_chk #(
  parameter int WA_W = 13,
  parameter int NB   = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            req_valid,
  input logic            req_ready,
  input logic [3:0]      req_op,
  input logic [2:0]      req_off,
  input logic [1:0]      req_size,
  input logic            rsp_valid,
  input logic            rsp_stored,
  input logic            rsp_err,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic            mem_req_we,
  input logic [WA_W-1:0] mem_req_addr,
  input logic [63:0]     mem_req_wdata,
  input logic [NB-1:0]   mem_req_be
);
  logic chk_mis;
  always_comb begin
    case (req_size)
      2'd0:    chk_mis = 1'b0;
      2'd1:    chk_mis = req_off[0];
      2'd2:    chk_mis = |req_off[1:0];
      default: chk_mis = |req_off;
    endcase
  end

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_req_valid);

  a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> !req_ready);

  a_r10_hold_request: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_we) && $stable(mem_req_wdata)));

  a_r7_misaligned_reject: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && chk_mis) |=> (rsp_valid && rsp_err && !mem_req_valid));

  a_r8_bad_opcode_reject: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op > 4'd9) |=> (rsp_valid && rsp_err && !mem_req_valid));

  a_r7_err_not_stored: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_err) |-> !rsp_stored);

  a_r11_single_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid);

  a_r6_be_width: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && mem_req_we) |->
      ($countones(mem_req_be) == 1 || $countones(mem_req_be) == 2 ||
       $countones(mem_req_be) == 4 || $countones(mem_req_be) == 8));
endmodule

bind amo_unit amo_unit_chk #(.WA_W(WA_W), .NB(NB)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_op(req_op), .req_off(req_addr[2:0]), .req_size(req_size),
  .rsp_valid(rsp_valid), .rsp_stored(rsp_stored), .rsp_err(rsp_err),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
  .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be)
);

// File: tb/sim_amo_unit.sv
module sim_amo_unit;
  localparam int AW = 9;
  localparam int NW = 1 << (AW - 3);

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          req_valid = 1'b0, req_ready;
  logic [3:0]    req_op = '0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = '0;
  logic [63:0]   req_opa = '0, req_opb = '0;
  logic          rsp_valid, rsp_stored, rsp_err;
  logic [63:0]   rsp_old;
  logic          mem_req_valid, mem_req_ready, mem_req_we;
  logic [AW-4:0] mem_req_addr;
  logic [63:0]   mem_req_wdata;
  logic [7:0]    mem_req_be;
  logic          mem_rsp_valid = 1'b0;
  logic [63:0]   mem_rsp_rdata = '0;

  amo_unit #(.DATA_W(64), .ADDR_W(AW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_addr(req_addr), .req_size(req_size),
    .req_opa(req_opa), .req_opb(req_opb), .rsp_valid(rsp_valid),
    .rsp_old(rsp_old), .rsp_stored(rsp_stored), .rsp_err(rsp_err),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  // memory model with periodic stalls
  logic [63:0]   mem [NW];
  logic [7:0]    cyc = '0;
  int            acc_total = 0;
  int            order_bad = 0;
  logic [AW-4:0] last_rd = '0;
  assign mem_req_ready = ~(cyc[0] & cyc[2]);

  always @(posedge clk) begin
    cyc <= cyc + 8'd1;
    mem_rsp_valid <= 1'b0;
    if (rst) begin
      for (int i = 0; i < NW; i++) mem[i] <= 64'h0F1E2D3C4B5A6978 + 64'h0101010101010101 * 64'(i);
    end else if (mem_req_valid && mem_req_ready) begin
      acc_total <= acc_total + 1;
      mem_rsp_valid <= 1'b1;
      if (mem_req_we) begin
        if (mem_req_addr != last_rd) order_bad <= order_bad + 1;
        for (int b = 0; b < 8; b++)
          if (mem_req_be[b]) mem[mem_req_addr][b*8 +: 8] <= mem_req_wdata[b*8 +: 8];
      end else begin
        last_rd <= mem_req_addr;
        mem_rsp_rdata <= mem[mem_req_addr];
      end
    end
  end

  int total = 0, bad = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // reference model built from the requirements
  function automatic void ref_op(input logic [3:0] op, input logic [1:0] sz,
      input logic [AW-1:0] addr, input logic [63:0] a, input logic [63:0] b,
      input logic [63:0] word, output logic [63:0] old, output logic [63:0] nw,
      output logic st, output logic err, output int nacc);
    int nb, off;
    logic [63:0] mask, lane, am, bm, res;
    logic signed [63:0] sl, sa;
    nb   = 1 << sz;
    off  = int'(addr[2:0]);
    mask = (nb == 8) ? '1 : ((64'd1 << (8 * nb)) - 64'd1);
    err  = ((off % nb) != 0) || (op > 4'd9);
    old = '0; nw = word; st = 1'b0; nacc = 0;
    if (err) return;
    lane = (word >> (8 * off)) & mask;
    am = a & mask; bm = b & mask;
    sl = $signed(lane << (64 - 8 * nb));
    sa = $signed(am << (64 - 8 * nb));
    old = lane; st = 1'b1; nacc = 2;
    case (op)
      4'd0: res = (lane + am) & mask;
      4'd1: res = lane ^ am;
      4'd2: res = lane | am;
      4'd3: res = lane & am;
      4'd4: res = (lane >= am) ? lane : am;
      4'd5: res = (sl >= sa) ? lane : am;
      4'd6: res = (lane <= am) ? lane : am;
      4'd7: res = (sl <= sa) ? lane : am;
      4'd8: res = am;
      default: begin
        res = am;
        if (lane != bm) begin st = 1'b0; nacc = 1; end
      end
    endcase
    if (st) nw = (word & ~(mask << (8 * off))) | ((res & mask) << (8 * off));
  endfunction

  // scoreboard queues
  logic [63:0] q_old[$], q_word[$];
  logic        q_st[$], q_err[$];
  int          q_acc[$], q_idx[$], q_start[$];
  string       q_tag[$];

  task automatic drive(input string tag, input logic [3:0] op, input logic [1:0] sz,
      input logic [AW-1:0] addr, input logic [63:0] a, input logic [63:0] b);
    logic [63:0] o, w;
    logic s, e;
    int n, idx;
    do @(negedge clk); while (!req_ready);
    idx = int'(addr[AW-1:3]);
    ref_op(op, sz, addr, a, b, mem[idx], o, w, s, e, n);
    q_old.push_back(o); q_word.push_back(w); q_st.push_back(s); q_err.push_back(e);
    q_acc.push_back(n); q_idx.push_back(idx); q_start.push_back(acc_total);
    q_tag.push_back(tag);
    req_valid = 1'b1; req_op = op; req_size = sz; req_addr = addr; req_opa = a; req_opb = b;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R9 busy after accept"}, 64'(req_ready), 64'd0);
  endtask

  // monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (q_tag.size() == 0) begin
        chk("R11 unexpected response", 64'd1, 64'd0);
      end else begin
        string t;
        t = q_tag.pop_front();
        chk({t, " old"}, rsp_old, q_old.pop_front());
        chk({t, " stored"}, 64'(rsp_stored), 64'(q_st.pop_front()));
        chk({t, " err"}, 64'(rsp_err), 64'(q_err.pop_front()));
        chk({t, " mem word"}, mem[q_idx.pop_front()], q_word.pop_front());
        chk({t, " R9 access count"}, 64'(acc_total - q_start.pop_front()), 64'(q_acc.pop_front()));
      end
    end
  end

  // watchdog
  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("reset req_ready", 64'(req_ready), 64'd1);
    chk("reset rsp_valid R11", 64'(rsp_valid), 64'd0);
    chk("reset mem_req_valid", 64'(mem_req_valid), 64'd0);

    drive("R4 swap64", 4'd8, 2'd3, 9'h018, 64'h11223344556677FF, '0);
    drive("R2 add8 wrap", 4'd0, 2'd0, 9'h018, 64'h1, '0);
    drive("R2 add16 wrap", 4'd0, 2'd1, 9'h01A, 64'hFFFF, '0);
    drive("R1 xor32", 4'd1, 2'd2, 9'h01C, 64'hF0F0F0F0, '0);
    drive("R1 or64", 4'd2, 2'd3, 9'h020, 64'h8000000000000101, '0);
    drive("R6 and8 lane7", 4'd3, 2'd0, 9'h027, 64'h0F, '0);
    drive("R6 add16 lane3", 4'd0, 2'd1, 9'h026, 64'h1234, '0);

    drive("R4 swap setup", 4'd8, 2'd3, 9'h028, 64'h00000000_7FFF0001, '0);
    drive("R3 smax8", 4'd5, 2'd0, 9'h028, 64'h80, '0);
    drive("R3 umax8", 4'd4, 2'd0, 9'h028, 64'h80, '0);
    drive("R3 smin8", 4'd7, 2'd0, 9'h028, 64'h01, '0);
    drive("R3 umin8", 4'd6, 2'd0, 9'h028, 64'h01, '0);
    drive("R3 smin16", 4'd7, 2'd1, 9'h02A, 64'h8000, '0);
    drive("R3 umin16", 4'd6, 2'd1, 9'h02A, 64'h0001, '0);
    drive("R3 smax32", 4'd5, 2'd2, 9'h02C, 64'hFFFFFFFF, '0);

    drive("R4 swap setup2", 4'd8, 2'd3, 9'h030, 64'hCAFEF00D_12345678, '0);
    drive("R5 cas hit", 4'd9, 2'd2, 9'h030, 64'hAAAA5555, 64'h12345678);
    drive("R5 cas miss", 4'd9, 2'd2, 9'h030, 64'h0, 64'h12345678);
    drive("R5 cas8 hit lane7", 4'd9, 2'd0, 9'h037, 64'h01, 64'hCA);
    drive("R5 cas64 miss", 4'd9, 2'd3, 9'h030, 64'h5, 64'h0);

    drive("R7 misaligned16", 4'd0, 2'd1, 9'h019, 64'h1, '0);
    drive("R7 misaligned64", 4'd8, 2'd3, 9'h01C, 64'h1, '0);
    drive("R7 misaligned32", 4'd2, 2'd2, 9'h01E, 64'h1, '0);
    drive("R8 bad opcode", 4'hC, 2'd0, 9'h018, 64'h1, '0);

    begin
      logic [31:0] lcg;
      lcg = 32'h1234ABCD;
      for (int k = 0; k < 40; k++) begin
        logic [3:0] op;
        logic [1:0] sz;
        logic [AW-1:0] ad;
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        op = 4'(lcg[27:24] % 10);
        sz = lcg[21:20];
        ad = AW'(lcg[15:7]) & ~AW'((1 << sz) - 1);
        drive("R1 R3 R6 mixed", op, sz, ad, {lcg, ~lcg}, {32'h0, lcg ^ 32'h5A5A5A5A});
      end
    end

    do @(negedge clk); while (q_tag.size() != 0 || !req_ready);
    chk("R9 write follows read of same word", 64'(order_bad), 64'd0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule